// File: doc/BRIEF.md
# Zero-Wait PCI Target Data-Phase Responder

This block answers transactions on a 32-bit PCI-style bus on behalf of internal apertures. One of these is a directly accessed register space. The others are buffered by FIFOs, whose state reaches the block as two status counts: free write space and prefetched read words. When the initiator opens a transaction that hits, the block claims it in the next clock. In that same clock it either starts moving data at once or tells the initiator to retry.

The block never holds the initiator off with target wait states. At the address phase it takes a snapshot of how many words the selected buffer can take or supply. It then keeps its ready line asserted for every data phase. On the word that uses up that allowance, it raises its stop line together with ready, so the burst ends with data moved. Each word moved produces a one-clock write strobe (writes) or a pop pulse (reads), and a per-transaction count.

Bus lines are active low. The block's names map to the PCI signals as follows: `txn_n` is the framing signal (FRAME#), `mrdy_n` is initiator ready (IRDY#), `claim_n` is the device-select response (DEVSEL#), `srdy_n` is target ready (TRDY#) and `halt_n` is the stop request (STOP#). All three responses are registered.

Top module: `pci_tgt_resp`

## Requirements
- R1: While `rst` is high, and in the clock after it, `claim_n`, `srdy_n` and `halt_n` are high and `beat_cnt` is 0.
- R2: An address phase is the first clock in which `txn_n` is sampled low. If `addr_hit` is high there and the credit is not zero, then in the next clock `claim_n` and `srdy_n` are both low.
- R3: A write command has `cmd[0]`=1. A write to a buffered aperture (`reg_hit`=0) with `wr_space`=0 is retried: in the next clock `claim_n` and `halt_n` are low and `srdy_n` is high. No word moves.
- R4: A read command has `cmd[0]`=0. A read from a buffered aperture with `rd_avail`=0 is retried in the same way as R3.
- R5: Once `srdy_n` is low it stays low, including during initiator wait clocks (`mrdy_n` high), until the final word of the transaction has moved.
- R6: The credit is `wr_space` (write) or `rd_avail` (read), sampled at the address phase. `halt_n` is low together with `srdy_n` exactly on the data phase that uses the last credit. After that word moves with `txn_n` still low, `srdy_n` goes high and `halt_n` stays low.
- R7: A hit with `reg_hit`=1 has a credit of exactly one word, whatever the FIFO status. It is never retried: the first data phase shows `srdy_n` and `halt_n` low together.
- R8: A word moves on each clock in which `mrdy_n` and `srdy_n` are both low. In that clock `wr_stb` pulses for a write and `rd_pop` pulses for a read; at no other time does either pulse. `beat_cnt` is cleared at each accepted address phase and counts the words moved; the transaction moves min(burst length, credit) words.
- R9: After a retry or a stop-ended burst, `claim_n` stays low until `txn_n` and `mrdy_n` are both sampled high. In the next clock all three responses are high.
- R10: When a word moves with `txn_n` high (the initiator's final data phase), all three responses are high in the next clock.
- R11: With `addr_hit` low at the address phase, the block does not respond during that transaction, even if `addr_hit` rises while `txn_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_n | input | 1 | Transaction framing from initiator, active low |
| mrdy_n | input | 1 | Initiator ready, active low |
| cmd | input | 4 | Bus command at address phase; bit 0 high means write |
| addr_hit | input | 1 | Address decodes to this block (address phase) |
| reg_hit | input | 1 | Hit lands in the unbuffered register aperture |
| wr_space | input | CW | Free words in the write FIFO |
| rd_avail | input | CW | Prefetched words ready in the read buffer |
| claim_n | output | 1 | Device-select response, active low |
| srdy_n | output | 1 | Target ready, active low |
| halt_n | output | 1 | Stop request (retry or disconnect), active low |
| wr_stb | output | 1 | One pulse per written word |
| rd_pop | output | 1 | One pulse per read word |
| beat_cnt | output | CW | Words moved in the current transaction |

## Verification
The bench builds the block with CW=3, so credits range from 0 to 7. This allows a full sweep over direction, aperture kind, every credit value, initiator burst lengths 1 to 8, and with or without initiator wait clocks. The sweep therefore covers every ordering of the two ends: the initiator finishing first, the target stopping first, and both on the same word (credit equal to burst length). It also covers retries for both directions and register hits against empty FIFO status.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } tgt_state_t;
endpackage

// File: rtl/pci_tgt_credit.sv
module pci_tgt_credit #(
  parameter int CW = 5
) (
  input  logic          is_wr,
  input  logic          reg_hit,
  input  logic [CW-1:0] wr_space,
  input  logic [CW-1:0] rd_avail,
  output logic [CW-1:0] credit
);
  localparam logic [CW-1:0] REG_WORDS = CW'(1);

  always_comb begin
    if (reg_hit)    credit = REG_WORDS;
    else if (is_wr) credit = wr_space;
    else            credit = rd_avail;
  end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_n,
  input  logic          mrdy_n,
  input  logic          addr_hit,
  input  logic          is_wr,
  input  logic [CW-1:0] credit,
  output logic          claim_n,
  output logic          srdy_n,
  output logic          halt_n,
  output logic          start,
  output logic          xfer,
  output logic          wr_dir
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  tgt_state_t    state;
  logic          txn_q;
  logic [CW-1:0] left;

  assign start = (state == ST_IDLE) && !txn_n && txn_q && addr_hit;
  assign xfer  = (state == ST_DATA) && !mrdy_n && !srdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      txn_q   <= 1'b1;
      left    <= '0;
      wr_dir  <= 1'b0;
      claim_n <= 1'b1;
      srdy_n  <= 1'b1;
      halt_n  <= 1'b1;
    end else begin
      txn_q <= txn_n;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wr_dir  <= is_wr;
            left    <= credit;
            claim_n <= 1'b0;
            if (credit == '0) begin
              state  <= ST_TAIL;
              srdy_n <= 1'b1;
              halt_n <= 1'b0;
            end else begin
              state  <= ST_DATA;
              srdy_n <= 1'b0;
              halt_n <= (credit != ONE);
            end
          end
        end
        ST_DATA: begin
          if (xfer) begin
            if (txn_n) begin
              state   <= ST_IDLE;
              claim_n <= 1'b1;
              srdy_n  <= 1'b1;
              halt_n  <= 1'b1;
            end else if (!halt_n) begin
              state  <= ST_TAIL;
              srdy_n <= 1'b1;
            end else begin
              left   <= left - ONE;
              halt_n <= (left != TWO);
            end
          end
        end
        ST_TAIL: begin
          if (txn_n && mrdy_n) begin
            state   <= ST_IDLE;
            claim_n <= 1'b1;
            srdy_n  <= 1'b1;
            halt_n  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_beats.sv
module pci_tgt_beats #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          xfer,
  output logic [CW-1:0] beat_cnt
);
  always_ff @(posedge clk) begin
    if (rst)        beat_cnt <= '0;
    else if (start) beat_cnt <= '0;
    else if (xfer)  beat_cnt <= beat_cnt + CW'(1);
  end
endmodule

// File: rtl/pci_tgt_resp.sv
module pci_tgt_resp #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_n,
  input  logic          mrdy_n,
  input  logic [3:0]    cmd,
  input  logic          addr_hit,
  input  logic          reg_hit,
  input  logic [CW-1:0] wr_space,
  input  logic [CW-1:0] rd_avail,
  output logic          claim_n,
  output logic          srdy_n,
  output logic          halt_n,
  output logic          wr_stb,
  output logic          rd_pop,
  output logic [CW-1:0] beat_cnt
);
  logic [CW-1:0] credit;
  logic          start;
  logic          xfer;
  logic          wr_dir;

  pci_tgt_credit #(.CW(CW)) u_credit (
    .is_wr    (cmd[0]),
    .reg_hit  (reg_hit),
    .wr_space (wr_space),
    .rd_avail (rd_avail),
    .credit   (credit)
  );

  pci_tgt_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .txn_n    (txn_n),
    .mrdy_n   (mrdy_n),
    .addr_hit (addr_hit),
    .is_wr    (cmd[0]),
    .credit   (credit),
    .claim_n  (claim_n),
    .srdy_n   (srdy_n),
    .halt_n   (halt_n),
    .start    (start),
    .xfer     (xfer),
    .wr_dir   (wr_dir)
  );

  pci_tgt_beats #(.CW(CW)) u_beats (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .xfer     (xfer),
    .beat_cnt (beat_cnt)
  );

  assign wr_stb = xfer &&  wr_dir;
  assign rd_pop = xfer && !wr_dir;
endmodule

// File: rtl/pci_tgt_resp_chk.sv
module pci_tgt_resp_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          txn_n,
  input logic          mrdy_n,
  input logic          claim_n,
  input logic          srdy_n,
  input logic          halt_n,
  input logic          wr_stb,
  input logic          rd_pop,
  input logic [CW-1:0] beat_cnt
);
  // R2
  first_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(claim_n) |-> (!srdy_n || !halt_n));

  // R5
  hold_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!srdy_n && mrdy_n) |=> !srdy_n);

  // R5
  no_wait_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!srdy_n && !mrdy_n && halt_n && !txn_n) |=> !srdy_n);

  // R6
  disconnect_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (!srdy_n && !halt_n && !mrdy_n && !txn_n) |=> (srdy_n && !halt_n && !claim_n));

  // R8
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_pop) |-> (!mrdy_n && !srdy_n && !(wr_stb && rd_pop)));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_pop) |=> (beat_cnt == $past(beat_cnt) + CW'(1)));

  // R9
  claim_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt_n || !srdy_n) |-> !claim_n);

  // R9
  tail_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!claim_n && srdy_n && txn_n && mrdy_n) |=> (claim_n && halt_n));

  // R10
  master_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!srdy_n && !mrdy_n && txn_n) |=> (claim_n && srdy_n && halt_n));
endmodule

bind pci_tgt_resp pci_tgt_resp_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .txn_n    (txn_n),
  .mrdy_n   (mrdy_n),
  .claim_n  (claim_n),
  .srdy_n   (srdy_n),
  .halt_n   (halt_n),
  .wr_stb   (wr_stb),
  .rd_pop   (rd_pop),
  .beat_cnt (beat_cnt)
);

// File: tb/pci_tgt_resp_bench.sv
module pci_tgt_resp_bench;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          txn_n = 1'b1;
  logic          mrdy_n = 1'b1;
  logic [3:0]    cmd = 4'b0000;
  logic          addr_hit = 1'b0;
  logic          reg_hit = 1'b0;
  logic [CW-1:0] wr_space = '0;
  logic [CW-1:0] rd_avail = '0;
  logic          claim_n, srdy_n, halt_n, wr_stb, rd_pop;
  logic [CW-1:0] beat_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pci_tgt_resp #(.CW(CW)) u_pci_tgt_resp (
    .clk(clk), .rst(rst), .txn_n(txn_n), .mrdy_n(mrdy_n), .cmd(cmd),
    .addr_hit(addr_hit), .reg_hit(reg_hit), .wr_space(wr_space),
    .rd_avail(rd_avail), .claim_n(claim_n), .srdy_n(srdy_n),
    .halt_n(halt_n), .wr_stb(wr_stb), .rd_pop(rd_pop), .beat_cnt(beat_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {claim_n, srdy_n, halt_n}, 7);
  endtask

  task automatic run_txn(input bit dir, input bit rg, input int cr, input int blen, input bit wt);
    int  eff, n, moved, cyc, waits, sbad;
    bit  retry, stopw, done, go;
    eff   = rg ? 1 : cr;
    retry = !rg && (cr == 0);
    n     = retry ? 0 : ((blen < eff) ? blen : eff);
    @(negedge clk);
    txn_n = 1'b0; mrdy_n = 1'b1; addr_hit = 1'b1; reg_hit = rg;
    cmd = dir ? 4'b0111 : 4'b0110;
    if (dir) begin wr_space = CW'(cr); rd_avail = CW'(7 - cr); end
    else     begin rd_avail = CW'(cr); wr_space = CW'(7 - cr); end
    @(negedge clk);
    addr_hit = 1'b0;
    if (retry) begin
      txn_n = 1'b1; mrdy_n = 1'b0; #3;
      chk(dir ? "R3 retry" : "R4 retry", {claim_n, srdy_n, halt_n}, 3'b010);
      @(negedge clk); mrdy_n = 1'b1; #3;
      chk("R9 claim held", claim_n, 0);
      @(negedge clk); #3;
      chk_idle("R9 release after retry");
      chk("R8 no words on retry", beat_cnt, 0);
      return;
    end
    mrdy_n = 1'b0; txn_n = (blen == 1); #3;
    chk("R2 claim", claim_n, 0);
    chk("R2 ready first clock", srdy_n, 0);
    if (rg) chk("R7 register single word", halt_n, 0);
    moved = 0; cyc = 0; waits = 0; sbad = 0; stopw = 0; done = 0;
    while (!done && cyc < 40) begin
      if (srdy_n) waits++;
      else if (!mrdy_n) begin
        moved++;
        if (wr_stb != dir || rd_pop != !dir) sbad++;
        if (!halt_n) stopw = 1;
        if (txn_n || !halt_n) done = 1;
      end else if (wr_stb || rd_pop) sbad++;
      if (!done) begin
        cyc++;
        @(negedge clk);
        go = !(wt && (cyc % 2 == 1));
        mrdy_n = !go;
        txn_n = go && (moved == blen - 1);
        #3;
      end
    end
    chk("R5 no target wait", waits, 0);
    chk("R8 strobe kind", sbad, 0);
    chk("R8 words moved", moved, n);
    chk(rg ? "R7 stop with data" : "R6 stop with data", stopw, (eff <= blen));
    if (txn_n) begin
      @(negedge clk); mrdy_n = 1'b1; #3;
      chk_idle("R10 release after final phase");
    end else begin
      @(negedge clk); txn_n = 1'b1; mrdy_n = 1'b0; #3;
      chk("R6 tail after disconnect", {claim_n, srdy_n, halt_n}, 3'b010);
      @(negedge clk); mrdy_n = 1'b1; #3;
      chk("R9 claim held", claim_n, 0);
      @(negedge clk); #3;
      chk_idle("R9 release after disconnect");
    end
    chk("R8 beat count", beat_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk_idle("R1 reset outputs");
    chk("R1 reset count", beat_cnt, 0);
    @(negedge clk); rst = 1'b0; #3;
    chk_idle("R1 after reset");

    // R11: miss at address phase, hit raised later in the same transaction
    @(negedge clk);
    txn_n = 1'b0; addr_hit = 1'b0; cmd = 4'b0111; wr_space = 3'd7; reg_hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      addr_hit = 1'b1; mrdy_n = 1'b0; #3;
      chk_idle("R11 no response on miss");
      chk("R11 no strobe", {wr_stb, rd_pop}, 0);
    end
    @(negedge clk); txn_n = 1'b1; addr_hit = 1'b0; #3;
    @(negedge clk); mrdy_n = 1'b1; #3;
    chk_idle("R11 still idle");

    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 8; c++)
          for (int b = 1; b <= 8; b++)
            for (int w = 0; w < 2; w++)
              run_txn(d[0], r[0], c, b, w[0]);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule